// File: doc/BRIEF.md
# Distributed MMIO window decoder

This block decides which downstream port of a host bridge owns a system bus address that falls inside a distributed memory-mapped I/O window. Two 64-bit configuration registers describe the window. The base register gives the window's start address and carries an enable flag. The route register sets the size of the slice that each port owns. Each of the eight ports owns one equal, contiguous slice, in port order, beginning at the base.

Software writes either register through a simple write/read port. On every write to either register the block cleans up the stored base: only a small group of address bits stays programmable, all bits above that group are forced high, and the result is aligned to the current slice size. A read returns the cleaned value. The lookup side is purely combinational. It takes a physical address and returns a hit flag, the index of the owning port, and the address to forward downstream.

Top module: `dmmio_window_decoder`

## Requirements
- R1: After reset both registers read as zero and no address hits the window.
- R2: A write with `cfg_wr_sel`=1 stores the 64-bit route value exactly as written, and a read with `cfg_rd_sel`=1 returns it.
- R3: A write with `cfg_wr_sel`=0 stores a cleaned base. Bits 28:24 are kept as written, bits 63:29 are forced to 1, bits 23:1 are 0, and bit 0 (the enable) is kept as written. A read with `cfg_rd_sel`=0 returns this stored value.
- R4: The log2 of the slice size is route bits 63:58, clamped to the range 20 to 23. A field below 20 gives a 1 MB slice and a field above 23 gives an 8 MB slice.
- R5: When base bit 0 is 0, `lk_hit` stays 0 for every address.
- R6: When the window is enabled, `lk_hit` is 1 exactly when base ≤ address < base + 8·slice. The comparison uses the full 64-bit address and accounts for a window that runs past the top of the address space.
- R7: On a hit, `lk_port` equals (address − base) divided by the slice size, so port n owns base + n·slice up to base + (n+1)·slice − 1.
- R8: `lk_fwd_addr` is the low 32 bits of the full system address, not the offset within the slice.
- R9: A route write cleans up the stored base again using the new slice size, on that same write, and keeps the enable bit.
- R10: The lookup outputs follow `lk_addr` and the register contents combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 base, 1 route |
| cfg_wr_data | input | 64 | Write data |
| cfg_rd_sel | input | 1 | Read source: 0 base, 1 route |
| cfg_rd_data | output | 64 | Read data |
| lk_addr | input | 64 | Physical address to decode |
| lk_hit | output | 1 | Address lies in the enabled window |
| lk_port | output | 3 | Index of the owning port |
| lk_fwd_addr | output | 32 | Address forwarded downstream |

## Verification
A stored base that was not cleaned up properly shows on the very next read, and it also moves the window. Addresses just inside or just outside a slice edge then hit the wrong port or miss, in the same cycle they are presented. A wrong clamp on the slice size shows as a port index that is off by a power of two, or as a miss near the window's upper end. The tests therefore probe the first and last byte of several slices under each clamp setting, and one window that wraps past the top of the address space.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  typedef logic [5:0] shift_t;

  // Clamp a raw log2 size into [lo, hi].
  function automatic shift_t clamp_shift(input shift_t raw, input shift_t lo, input shift_t hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // Rebuild a base: keep [khi:klo], force ones above khi,
  // clear below the slice alignment, preserve the enable in bit 0.
  function automatic logic [63:0] build_base(input logic [63:0] raw, input shift_t sh,
                                             input int klo, input int khi);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      if (i > khi)                         r[i] = 1'b1;
      else if (i >= klo && i >= int'(sh))  r[i] = raw[i];
      else                                 r[i] = 1'b0;
    end
    r[0] = raw[0];
    return r;
  endfunction
endpackage

// File: rtl/dmw_regs.sv
module dmw_regs import dmw_pkg::*; #(
  parameter int SHIFT_MIN = 20,
  parameter int SHIFT_MAX = 23,
  parameter int KEEP_LO   = 24,
  parameter int KEEP_HI   = 28,
  parameter int ROUTE_LSB = 58
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [63:0] wr_data,
  output logic [63:0] base_q,
  output logic [63:0] route_q,
  output shift_t      cur_shift
);
  localparam shift_t SH_LO = shift_t'(SHIFT_MIN);
  localparam shift_t SH_HI = shift_t'(SHIFT_MAX);

  // named events for the assertions
  logic   base_wr_ev, route_wr_ev;
  shift_t new_shift;

  assign base_wr_ev  = wr_en && !wr_sel;
  assign route_wr_ev = wr_en &&  wr_sel;
  assign cur_shift   = clamp_shift(shift_t'(route_q[63:ROUTE_LSB]), SH_LO, SH_HI);
  assign new_shift   = clamp_shift(shift_t'(wr_data[63:ROUTE_LSB]), SH_LO, SH_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      route_q <= '0;
    end else if (base_wr_ev) begin
      base_q  <= build_base(wr_data, cur_shift, KEEP_LO, KEEP_HI);
    end else if (route_wr_ev) begin
      route_q <= wr_data;
      base_q  <= build_base(base_q, new_shift, KEEP_LO, KEEP_HI);
    end
  end

  // R2
  route_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_wr_ev |=> route_q == $past(wr_data));
  // R3
  base_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_ev |=> base_q[0] == $past(wr_data[0]));
  // R3
  base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[KEEP_LO-1:1] == '0);
  // R9
  route_keeps_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_wr_ev |=> base_q[0] == $past(base_q[0]));
endmodule

// File: rtl/dmw_lookup.sv
module dmw_lookup import dmw_pkg::*; #(
  parameter int PORTS = 8,
  parameter int FWD_W = 32,
  localparam int PW   = $clog2(PORTS)
) (
  input  logic [63:0]      base_q,
  input  shift_t           cur_shift,
  input  logic [63:0]      addr,
  output logic             hit,
  output logic [PW-1:0]    port,
  output logic [FWD_W-1:0] fwd_addr
);
  logic [63:0] base_addr, diff, idx;
  logic        above;

  assign base_addr = {base_q[63:1], 1'b0};
  assign above     = addr >= base_addr;
  assign diff      = addr - base_addr;
  assign idx       = diff >> cur_shift;
  assign hit       = base_q[0] && above && (idx < 64'(PORTS));
  assign port      = idx[PW-1:0];
  assign fwd_addr  = addr[FWD_W-1:0];
endmodule

// File: rtl/dmmio_window_decoder.sv
module dmmio_window_decoder import dmw_pkg::*; #(
  parameter int PORTS     = 8,
  parameter int SHIFT_MIN = 20,
  parameter int SHIFT_MAX = 23,
  parameter int KEEP_LO   = 24,
  parameter int KEEP_HI   = 28,
  parameter int ROUTE_LSB = 58,
  parameter int FWD_W     = 32,
  localparam int PW       = $clog2(PORTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic             cfg_wr_sel,
  input  logic [63:0]      cfg_wr_data,
  input  logic             cfg_rd_sel,
  output logic [63:0]      cfg_rd_data,
  input  logic [63:0]      lk_addr,
  output logic             lk_hit,
  output logic [PW-1:0]    lk_port,
  output logic [FWD_W-1:0] lk_fwd_addr
);
  logic [63:0] base_q, route_q;
  shift_t      cur_shift;

  dmw_regs #(.SHIFT_MIN(SHIFT_MIN), .SHIFT_MAX(SHIFT_MAX), .KEEP_LO(KEEP_LO),
             .KEEP_HI(KEEP_HI), .ROUTE_LSB(ROUTE_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
    .wr_data(cfg_wr_data), .base_q(base_q), .route_q(route_q), .cur_shift(cur_shift));

  dmw_lookup #(.PORTS(PORTS), .FWD_W(FWD_W)) u_lookup (
    .base_q(base_q), .cur_shift(cur_shift), .addr(lk_addr),
    .hit(lk_hit), .port(lk_port), .fwd_addr(lk_fwd_addr));

  assign cfg_rd_data = cfg_rd_sel ? route_q : base_q;

  // R5
  off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !base_q[0] |-> !lk_hit);
  // R6
  hit_above_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_addr >= {base_q[63:1], 1'b0});
  // R4
  shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cur_shift) >= SHIFT_MIN) && (int'(cur_shift) <= SHIFT_MAX));
endmodule

// File: tb/dmmio_window_decoder_test.sv
module dmmio_window_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_wr_sel = 1'b0, cfg_rd_sel = 1'b0;
  logic [63:0] cfg_wr_data = '0, cfg_rd_data, lk_addr = '0;
  logic        lk_hit;
  logic [2:0]  lk_port;
  logic [31:0] lk_fwd_addr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dmmio_window_decoder uut (.*);

  typedef struct packed {
    logic [63:0] route; logic [63:0] base_w; logic [63:0] base_exp;
    logic [63:0] addr;  logic hit; logic [2:0] port; logic [31:0] fwd;
  } vec_t;

  localparam logic [63:0] RT20 = 64'h5000_0000_0000_0000;
  localparam logic [63:0] RT21 = 64'h5400_0000_0000_0000;
  localparam logic [63:0] RT63 = 64'hFC00_0000_0000_0000;
  localparam logic [63:0] RT00 = 64'h0000_0000_0000_0123;
  localparam logic [63:0] BW3  = 64'h0000_0000_0300_0001;
  localparam logic [63:0] BE3  = 64'hFFFF_FFFF_E300_0001;
  localparam logic [63:0] BW31 = 64'h0000_0000_1F00_0001;
  localparam logic [63:0] BE31 = 64'hFFFF_FFFF_FF00_0001;
  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{RT20, BW3, BE3, 64'hFFFF_FFFF_E300_0000, 1'b1, 3'd0, 32'hE300_0000},
    '{RT20, BW3, BE3, 64'hFFFF_FFFF_E33F_FFFF, 1'b1, 3'd3, 32'hE33F_FFFF},
    '{RT20, BW3, BE3, 64'hFFFF_FFFF_E37F_FFFF, 1'b1, 3'd7, 32'hE37F_FFFF},
    '{RT20, BW3, BE3, 64'hFFFF_FFFF_E380_0000, 1'b0, 3'd0, 32'hE380_0000},
    '{RT20, BW3, BE3, 64'hFFFF_FFFF_E2FF_FFFF, 1'b0, 3'd0, 32'hE2FF_FFFF},
    '{RT63, BW3, BE3, 64'hFFFF_FFFF_E580_0000, 1'b1, 3'd5, 32'hE580_0000},
    '{RT63, BW3, BE3, 64'hFFFF_FFFF_E6FF_FFFF, 1'b1, 3'd7, 32'hE6FF_FFFF},
    '{RT63, BW3, BE3, 64'hFFFF_FFFF_E700_0000, 1'b0, 3'd0, 32'hE700_0000},
    '{RT00, BW3, BE3, 64'hFFFF_FFFF_E310_0000, 1'b1, 3'd1, 32'hE310_0000},
    '{RT21, BW3, BE3, 64'hFFFF_FFFF_E3C0_0000, 1'b1, 3'd6, 32'hE3C0_0000},
    '{RT21, BW3, BE3, 64'hFFFF_FFFF_E400_0000, 1'b0, 3'd0, 32'hE400_0000},
    '{RT63, BW31, BE31, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3'd1, 32'hFFFF_FFFF},
    '{RT63, BW31, BE31, 64'h0000_0000_0000_0000, 1'b0, 3'd0, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [63:0] d);
    cfg_rd_sel = sel; #1; d = cfg_rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, r); chk("R1 base", r, 64'h0);
    rd(1'b1, r); chk("R1 route", r, 64'h0);
    lk_addr = 64'hFFFF_FFFF_E000_0000; #1;
    chk("R1 hit", {63'h0, lk_hit}, 64'h0);

    // table walk: R2 R3 R4 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, VT[i].route);
      wr(1'b0, VT[i].base_w);
      rd(1'b1, r); chk("R2 route readback", r, VT[i].route);
      rd(1'b0, r); chk("R3 base readback", r, VT[i].base_exp);
      lk_addr = VT[i].addr; #1;   // R10: no clock edge needed
      chk("R6 hit", {63'h0, lk_hit}, {63'h0, VT[i].hit});
      chk("R8 fwd", {32'h0, lk_fwd_addr}, {32'h0, VT[i].fwd});
      if (VT[i].hit) chk("R7 R4 port", {61'h0, lk_port}, {61'h0, VT[i].port});
    end

    // R3 garbage base, enable clear -> R5 no hit anywhere
    wr(1'b1, RT63);
    wr(1'b0, 64'h1234_5678_9ABC_DEF0);
    rd(1'b0, r); chk("R3 garbage base", r, 64'hFFFF_FFFF_FA00_0000);
    lk_addr = 64'hFFFF_FFFF_FA00_0000; #1;
    chk("R5 disabled lo", {63'h0, lk_hit}, 64'h0);
    lk_addr = 64'hFFFF_FFFF_FB23_4567; #1;
    chk("R5 disabled mid", {63'h0, lk_hit}, 64'h0);

    // R9 route write re-cleans base and keeps enable
    wr(1'b0, BW3);
    wr(1'b1, RT20);
    rd(1'b0, r); chk("R9 base after route", r, BE3);
    // R10 lookup follows new slice immediately after the write
    lk_addr = 64'hFFFF_FFFF_E310_0000; #1;
    chk("R10 port after route", {61'h0, lk_port}, 64'd1);
    lk_addr = 64'hFFFF_FFFF_E390_0000; #1;
    chk("R10 miss after route", {63'h0, lk_hit}, 64'h0);
    finish_run();
  end
endmodule